// File: doc/BRIEF.md
# Halfword Multiply-Accumulate Execution Unit

This unit decodes and executes one class of 32-bit multiply-accumulate instructions. Each instruction selects one 16-bit half of each of two 32-bit source operands and multiplies the two halves, treating them as either signed or unsigned. The product may be doubled. It is then added to or subtracted from a 32-bit accumulator, which is both a source and the destination. Signed forms can optionally saturate to the 32-bit signed range.

The surrounding pipeline supplies four things: the instruction word, the current accumulator value, the two source operand values, and a one-cycle `issue_i` strobe. One cycle after the strobe, the unit presents its outputs:

- the new accumulator value;
- the three register indices it decoded;
- a match pulse, raised when the word is a legal member of the class;
- an overflow pulse, raised when saturation actually clamped the result.

The overflow pulse lets a sticky status bit be kept elsewhere. Register file access, packet parsing and hazard handling belong to the caller.

Top module: `hmac_unit`

## Requirements
- R1: A word is in the class only when bits 31..24 equal 0xEE. A word outside the class produces no match pulse and leaves the result and index outputs unchanged.
- R2: A word with bit 22 (unsigned) and bit 7 (saturate) both set is illegal. It produces no match pulse and leaves the result and index outputs unchanged.
- R3: On a legal issue, the index outputs take these instruction fields: destination from bits 4..0, first source from bits 20..16, second source from bits 12..8.
- R4: Bit 6 set selects the upper 16 bits of the first operand, and clear selects the lower 16 bits. Bit 5 selects the half of the second operand in the same way.
- R5: Bit 22 clear multiplies the halves as two's-complement values. Bit 22 set multiplies them as unsigned values.
- R6: Bit 23 set doubles the product before accumulation.
- R7: Bit 21 clear adds the product to the accumulator, and bit 21 set subtracts it. Without saturation, the result wraps modulo 2^32.
- R8: With bit 7 set, the exact result is clamped to 0x7FFFFFFF when above the signed range and to 0x80000000 when below it.
- R9: `ovf_o` is high for exactly the cycle whose result was clamped by saturation, and low otherwise.
- R10: Outputs are registered one cycle after `issue_i`. `match_o` is high only in the cycle after a legal issue. Without an issue, the result and index outputs hold their values.
- R11: Bits 15..13 have no effect on any output.
- R12: After reset, all outputs are zero.
- R13: Word 0xEE95DF11 gives destination 17, first source 21, second source 31, and a signed low-by-low doubled add without saturation. Word 0xEEB5DF11 gives the same operation as a subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Instruction word |
| acc_i | input | 32 | Current accumulator value |
| src_a_i | input | 32 | First source operand |
| src_b_i | input | 32 | Second source operand |
| res_o | output | 32 | New accumulator value |
| dst_idx_o | output | 5 | Decoded destination index |
| src_a_idx_o | output | 5 | Decoded first source index |
| src_b_idx_o | output | 5 | Decoded second source index |
| match_o | output | 1 | Legal instruction executed last cycle |
| ovf_o | output | 1 | Saturation clamped the result |

## Verification
The hardest situations to reach are saturation at its edges. One is the single signed case where both halves are 0x8000: doubled, that product is exactly 2^31 and overflows only because of the doubling. The other is an accumulator that sits next to a limit while a product pushes it across. Uniform random operands almost never land there, so the random stream biases the accumulator toward 0x7FFFFFFF and 0x80000000 and biases the halves toward 0x8000 and 0x7FFF. Directed cases add the exact boundary values, including a clamp to each limit and a result that lands exactly on a limit without overflow.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
  localparam int INSN_W  = 32;
  localparam int IDX_W   = 5;
  localparam logic [7:0] CLASS_CODE = 8'hEE;

  // field positions inside the instruction word
  localparam int POS_DBL   = 23;
  localparam int POS_UNS   = 22;
  localparam int POS_SUB   = 21;
  localparam int POS_SAT   = 7;
  localparam int POS_HI_A  = 6;
  localparam int POS_HI_B  = 5;
  localparam int POS_DST   = 0;
  localparam int POS_SRC_A = 16;
  localparam int POS_SRC_B = 8;

  typedef struct packed {
    logic hi_a;
    logic hi_b;
    logic uns;
    logic dbl;
    logic sub;
    logic sat;
  } hmac_ctrl_t;
endpackage

// File: rtl/hmac_decode.sv
module hmac_decode
  import hmac_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output hmac_ctrl_t        ctrl,
  output logic [IDX_W-1:0]  dst_idx,
  output logic [IDX_W-1:0]  src_a_idx,
  output logic [IDX_W-1:0]  src_b_idx,
  output logic              legal
);
  logic in_class;

  always_comb begin
    in_class  = (insn[INSN_W-1 -: 8] == CLASS_CODE);
    ctrl.hi_a = insn[POS_HI_A];
    ctrl.hi_b = insn[POS_HI_B];
    ctrl.uns  = insn[POS_UNS];
    ctrl.dbl  = insn[POS_DBL];
    ctrl.sub  = insn[POS_SUB];
    ctrl.sat  = insn[POS_SAT];
    dst_idx   = insn[POS_DST   +: IDX_W];
    src_a_idx = insn[POS_SRC_A +: IDX_W];
    src_b_idx = insn[POS_SRC_B +: IDX_W];
    // saturation is defined for signed forms only
    legal     = in_class && !(insn[POS_UNS] && insn[POS_SAT]);
  end
endmodule

// File: rtl/hmac_mult.sv
module hmac_mult #(
  parameter int HALF_W = 16,
  localparam int DATA_W = 2 * HALF_W,
  localparam int RAW_W  = 2 * HALF_W + 2,
  localparam int PROD_W = RAW_W + 1
) (
  input  logic [DATA_W-1:0]        src_a,
  input  logic [DATA_W-1:0]        src_b,
  input  logic                     hi_a,
  input  logic                     hi_b,
  input  logic                     uns,
  input  logic                     dbl,
  output logic signed [PROD_W-1:0] prod
);
  logic [HALF_W-1:0]        half_a;
  logic [HALF_W-1:0]        half_b;
  logic signed [HALF_W:0]   ext_a;
  logic signed [HALF_W:0]   ext_b;
  logic signed [RAW_W-1:0]  raw;

  always_comb begin
    half_a = hi_a ? src_a[DATA_W-1 -: HALF_W] : src_a[HALF_W-1:0];
    half_b = hi_b ? src_b[DATA_W-1 -: HALF_W] : src_b[HALF_W-1:0];
    // one extra bit carries either the sign or a zero
    ext_a  = {(uns ? 1'b0 : half_a[HALF_W-1]), half_a};
    ext_b  = {(uns ? 1'b0 : half_b[HALF_W-1]), half_b};
    raw    = ext_a * ext_b;
    prod   = dbl ? {raw, 1'b0} : {raw[RAW_W-1], raw};
  end
endmodule

// File: rtl/hmac_accum.sv
module hmac_accum #(
  parameter int DATA_W = 32,
  parameter int PROD_W = 35,
  localparam int EXT_W  = PROD_W + 1,
  localparam int ACC_PAD = EXT_W - DATA_W,
  localparam int PRD_PAD = EXT_W - PROD_W,
  localparam int TOP_W  = EXT_W - DATA_W + 1
) (
  input  logic [DATA_W-1:0]        acc,
  input  logic signed [PROD_W-1:0] prod,
  input  logic                     sub,
  input  logic                     sat,
  output logic [DATA_W-1:0]        res,
  output logic                     clamp
);
  localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [EXT_W-1:0] acc_x;
  logic [EXT_W-1:0] prod_x;
  logic [EXT_W-1:0] sum;
  logic [TOP_W-1:0] top;
  logic             fits;

  always_comb begin
    acc_x  = {{ACC_PAD{acc[DATA_W-1]}}, acc};
    prod_x = {{PRD_PAD{prod[PROD_W-1]}}, prod};
    sum    = sub ? (acc_x - prod_x) : (acc_x + prod_x);
    top    = sum[EXT_W-1:DATA_W-1];
    fits   = (&top) || !(|top);
    clamp  = sat && !fits;
    if (clamp) res = sum[EXT_W-1] ? SMIN : SMAX;
    else       res = sum[DATA_W-1:0];
  end
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
  import hmac_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int DATA_W = 2 * HALF_W,
  localparam int PROD_W = 2 * HALF_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [31:0]       insn_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic [DATA_W-1:0] res_o,
  output logic [4:0]        dst_idx_o,
  output logic [4:0]        src_a_idx_o,
  output logic [4:0]        src_b_idx_o,
  output logic              match_o,
  output logic              ovf_o
);
  hmac_ctrl_t               ctrl;
  logic [IDX_W-1:0]         dec_dst, dec_sa, dec_sb;
  logic                     legal;
  logic signed [PROD_W-1:0] prod;
  logic [DATA_W-1:0]        acc_res;
  logic                     clamp;

  logic [DATA_W-1:0] res_q, res_d;
  logic [IDX_W-1:0]  dst_q, dst_d, sa_q, sa_d, sb_q, sb_d;
  logic              match_q, match_d, ovf_q, ovf_d;
  logic              fire;

  hmac_decode u_dec (
    .insn(insn_i), .ctrl(ctrl), .dst_idx(dec_dst),
    .src_a_idx(dec_sa), .src_b_idx(dec_sb), .legal(legal)
  );

  hmac_mult #(.HALF_W(HALF_W)) u_mul (
    .src_a(src_a_i), .src_b(src_b_i), .hi_a(ctrl.hi_a), .hi_b(ctrl.hi_b),
    .uns(ctrl.uns), .dbl(ctrl.dbl), .prod(prod)
  );

  hmac_accum #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_acc (
    .acc(acc_i), .prod(prod), .sub(ctrl.sub), .sat(ctrl.sat),
    .res(acc_res), .clamp(clamp)
  );

  // next-state
  always_comb begin
    fire    = issue_i && legal;
    res_d   = fire ? acc_res : res_q;
    dst_d   = fire ? dec_dst : dst_q;
    sa_d    = fire ? dec_sa  : sa_q;
    sb_d    = fire ? dec_sb  : sb_q;
    match_d = fire;
    ovf_d   = fire && clamp;
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      dst_q   <= '0;
      sa_q    <= '0;
      sb_q    <= '0;
      match_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      res_q   <= res_d;
      dst_q   <= dst_d;
      sa_q    <= sa_d;
      sb_q    <= sb_d;
      match_q <= match_d;
      ovf_q   <= ovf_d;
    end
  end

  assign res_o       = res_q;
  assign dst_idx_o   = dst_q;
  assign src_a_idx_o = sa_q;
  assign src_b_idx_o = sb_q;
  assign match_o     = match_q;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/hmac_unit_chk.sv
module hmac_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        issue_i,
  input logic [31:0] insn_i,
  input logic [31:0] res_o,
  input logic [4:0]  dst_idx_o,
  input logic        match_o,
  input logic        ovf_o
);
  // R1
  class_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(issue_i) && ($past(insn_i[31:24]) == 8'hEE));
  // R2
  legal_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> !($past(insn_i[22]) && $past(insn_i[7])));
  // R3
  dst_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> dst_idx_o == $past(insn_i[4:0]));
  // R8
  clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (res_o == 32'h7FFFFFFF) || (res_o == 32'h80000000));
  // R9
  ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> match_o && $past(insn_i[7]));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !match_o |-> $stable(res_o) && $stable(dst_idx_o));
endmodule

bind hmac_unit hmac_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .insn_i(insn_i),
  .res_o(res_o), .dst_idx_o(dst_idx_o), .match_o(match_o), .ovf_o(ovf_o)
);

// File: tb/hmac_unit_test.sv
module hmac_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [31:0] insn_i = '0, acc_i = '0, src_a_i = '0, src_b_i = '0;
  logic [31:0] res_o;
  logic [4:0]  dst_idx_o, src_a_idx_o, src_b_idx_o;
  logic        match_o, ovf_o;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  hmac_unit uut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .insn_i(insn_i),
    .acc_i(acc_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .res_o(res_o),
    .dst_idx_o(dst_idx_o), .src_a_idx_o(src_a_idx_o),
    .src_b_idx_o(src_b_idx_o), .match_o(match_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint half_val(input logic [31:0] v, input bit hi, input bit uns);
    logic [15:0] h;
    h = hi ? v[31:16] : v[15:0];
    return uns ? longint'({48'b0, h}) : longint'({{48{h[15]}}, h});
  endfunction

  // expected {ovf, result}
  function automatic logic [32:0] model(input logic [31:0] w, input logic [31:0] a,
                                        input logic [31:0] s, input logic [31:0] t);
    longint p, r;
    bit ov;
    p = half_val(s, w[6], w[22]) * half_val(t, w[5], w[22]);
    if (w[23]) p = p * 2;
    r = longint'({{32{a[31]}}, a});
    r = w[21] ? r - p : r + p;
    ov = 0;
    if (w[7]) begin
      if (r > 64'sh7FFFFFFF) begin r = 64'sh7FFFFFFF; ov = 1; end
      else if (r < -64'sh80000000) begin r = -64'sh80000000; ov = 1; end
    end
    return {ov, r[31:0]};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] s, input logic [31:0] t);
    @(negedge clk);
    insn_i = w; acc_i = a; src_a_i = s; src_b_i = t; issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
  endtask

  task automatic run_legal(input string req, input logic [31:0] w, input logic [31:0] a,
                           input logic [31:0] s, input logic [31:0] t);
    logic [32:0] e;
    e = model(w, a, s, t);
    issue(w, a, s, t);
    chk({req, " result"}, res_o, e[31:0]);
    chk({req, " R9 ovf"}, {31'b0, ovf_o}, {31'b0, e[32]});
    chk({req, " R10 match"}, {31'b0, match_o}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    logic [32:0] e;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 res", res_o, 0);
    chk("R12 idx", {17'b0, dst_idx_o, src_a_idx_o, src_b_idx_o}, 0);
    chk("R12 flags", {30'b0, match_o, ovf_o}, 0);
    rst_n = 1'b1;

    // R13 example words, R3 fields
    run_legal("R13 add", 32'hEE95DF11, 32'h00000010, 32'h0000FFFE, 32'h00000003);
    chk("R13 add value", res_o, 32'h00000004);
    chk("R3 R13 dst", {27'b0, dst_idx_o}, 17);
    chk("R3 R13 srca", {27'b0, src_a_idx_o}, 21);
    chk("R3 R13 srcb", {27'b0, src_b_idx_o}, 31);
    run_legal("R13 sub", 32'hEEB5DF11, 32'h00000010, 32'h0000FFFE, 32'h00000003);
    chk("R13 sub value", res_o, 32'h0000001C);

    // R10 idle hold
    held = res_o;
    @(negedge clk);
    chk("R10 match low idle", {31'b0, match_o}, 0);
    chk("R10 res held", res_o, held);

    // R1 wrong class
    issue(32'hEC95DF03, 32'h1234, 32'h5, 32'h7);
    chk("R1 no match", {31'b0, match_o}, 0);
    chk("R1 res held", res_o, held);
    chk("R1 dst held", {27'b0, dst_idx_o}, 17);

    // R2 unsigned + sat illegal
    issue(32'hEED5DF83, 32'h1234, 32'h5, 32'h7);
    chk("R2 no match", {31'b0, match_o}, 0);
    chk("R2 res held", res_o, held);
    chk("R2 dst held", {27'b0, dst_idx_o}, 17);

    // R4 half selection, R5 signedness
    run_legal("R4 hi/lo", 32'hEE000040, 32'h0, 32'h0003_0005, 32'h0007_000B);
    chk("R4 hi_a*lo_b", res_o, 32'd33);
    run_legal("R4 lo/hi", 32'hEE000020, 32'h0, 32'h0003_0005, 32'h0007_000B);
    chk("R4 lo_a*hi_b", res_o, 32'd35);
    run_legal("R5 signed", 32'hEE000000, 32'h0, 32'h0000FFFF, 32'h0000FFFF);
    chk("R5 signed value", res_o, 32'd1);
    run_legal("R5 unsigned", 32'hEE400000, 32'h0, 32'h0000FFFF, 32'h0000FFFF);
    chk("R5 unsigned value", res_o, 32'hFFFE0001);

    // R6 doubling, R7 wrap
    run_legal("R6 dbl", 32'hEE800000, 32'h0, 32'h00000003, 32'h00000004);
    chk("R6 dbl value", res_o, 32'd24);
    run_legal("R7 wrap", 32'hEE800000, 32'h0, 32'h00008000, 32'h00008000);
    chk("R7 wrap value", res_o, 32'h80000000);
    chk("R7 no ovf", {31'b0, ovf_o}, 0);

    // R8 R9 saturation corners
    run_legal("R8 dbl edge", 32'hEE800080, 32'h0, 32'h00008000, 32'h00008000);
    chk("R8 clamp hi", res_o, 32'h7FFFFFFF);
    chk("R9 ovf set", {31'b0, ovf_o}, 1);
    run_legal("R8 low", 32'hEE200080, 32'h80000000, 32'h1, 32'h1);
    chk("R8 clamp lo", res_o, 32'h80000000);
    run_legal("R8 exact", 32'hEE000080, 32'h7FFFFFFE, 32'h1, 32'h1);
    chk("R8 exact limit", res_o, 32'h7FFFFFFF);
    chk("R9 no ovf exact", {31'b0, ovf_o}, 0);
    @(negedge clk);
    chk("R9 pulse ends", {31'b0, ovf_o}, 0);

    // R11 ignored bits
    for (int k = 0; k < 8; k++) begin
      logic [31:0] w;
      w = 32'hEEA5DF71 | (32'(k) << 13);
      e = model(32'hEEA5DF71, 32'h11111111, 32'h89AB_CDEF, 32'h1357_9BDF);
      issue(w, 32'h11111111, 32'h89AB_CDEF, 32'h1357_9BDF);
      chk("R11 ignored bits result", res_o, e[31:0]);
    end

    // random with biased corners: R3 R4 R5 R6 R7 R8 R9
    void'($urandom(32'h5EED));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w, a, s, t;
      w = 32'hEE000000 | ($urandom() & 32'h00FFFFFF);
      if (w[22]) w[7] = 1'b0;
      a = $urandom();
      s = $urandom();
      t = $urandom();
      case ($urandom_range(3))
        0: a = 32'h7FFFFFFF - $urandom_range(1000);
        1: a = 32'h80000000 + $urandom_range(1000);
        default: ;
      endcase
      if ($urandom_range(3) == 0) begin s = 32'h80008000; t = 32'h80008000; end
      if ($urandom_range(4) == 0) begin s = 32'h7FFF7FFF; end
      run_legal("R4 R5 R6 R7 R8 random", w, a, s, t);
      chk("R3 random dst", {27'b0, dst_idx_o}, {27'b0, w[4:0]});
      chk("R3 random srca", {27'b0, src_a_idx_o}, {27'b0, w[20:16]});
      chk("R3 random srcb", {27'b0, src_b_idx_o}, {27'b0, w[12:8]});
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule